// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a clocked serial port that acts as bus master. It generates the shift clock itself from a programmable divider and captures the data line once per bit. Words are 8 or 9 bits long and arrive least significant bit first. Software controls the block through a small register port: one control byte and two divider bytes.

There are two ways to start a receive. A single-shot enable captures one word and then clears itself. A continuous enable keeps the clock running word after word until software clears it. A finished word is held in an output register with a ready flag, and an interrupt request follows that flag when it is enabled. If a word finishes while the previous one is still unread, an overrun is latched. It stays latched until software clears the continuous enable.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `ctl_state`, `rx_ready`, `rx_irq`, `rx_ovr` and `sck_pin` are all 0.
- R2: A write to address 0 loads the control byte, which reads back on `ctl_state` with bit 7 forced to 0. The control fields are: bit0 single, bit1 continuous, bit2 nine-bit, bit3 idle-high, bit4 wide divider, bit5 fast, bit6 interrupt enable. Address 1 writes the divider low byte and address 2 writes the divider high byte.
- R3: The half period is H = (D+1) clock cycles when fast is set, and 4*(D+1) when it is clear. D is the 16-bit divider when wide is set, and only its low byte otherwise. In every bit the clock sits at its active level for H cycles and then at its idle level for H cycles.
- R4: `sdi_pin` is sampled at the moment the clock returns from its active level to idle. Bits are assembled least significant bit first.
- R5: With only single set, exactly one word is received. The single bit then clears itself and the clock stays idle.
- R6: With continuous set, words follow back to back for as long as the bit stays set. Clearing both enables in the middle of a word stops the clock at its idle level, and no word is completed.
- R7: With both enables set, reception is continuous and the single bit is not cleared.
- R8: In nine-bit mode, the first 8 bits go to `rx_data` and the ninth goes to `rx_bit9`. In 8-bit mode, `rx_bit9` reads 0.
- R9: `rx_ready` rises when a word is loaded, and a pulse on `rx_pop` clears it. `rx_irq` equals `rx_ready` AND the interrupt enable on every cycle.
- R10: A word that completes while `rx_ready` is set, with no pop in the same cycle, sets `rx_ovr` and leaves `rx_data` unchanged. While `rx_ovr` is set, no completed word is loaded.
- R11: `rx_ovr` is cleared only by a control write that clears a continuous bit that was set.
- R12: When reception is inactive, `sck_pin` sits at the idle-high bit; the active level is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Register write strobe |
| ctl_addr | input | 2 | Register address (0 control, 1 divider low, 2 divider high) |
| ctl_wdata | input | 8 | Register write data |
| rx_pop | input | 1 | Read strobe for the received word; clears ready |
| sdi_pin | input | 1 | Serial data line |
| ctl_state | output | 8 | Current control byte |
| rx_data | output | 8 | Received word (low 8 bits) |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_ready | output | 1 | Received word is waiting |
| rx_irq | output | 1 | Receive interrupt request |
| rx_ovr | output | 1 | Overrun latched |
| sck_pin | output | 1 | Generated shift clock |

## Verification
The bench builds the block with its default widths: a 16-bit divider, 8-bit words and a slow-mode multiplier of 4. With these defaults both the byte-wide and the full 16-bit divider paths can be checked, including a half period of several hundred cycles, while narrow settings keep whole words down to a few dozen cycles. The bench drives the data line the way a serial slave would, shifting after every sampling edge, and it times every active clock phase against its own half-period formula. Those short periods let continuous runs reach overrun, recovery from it, and an abort in the middle of a word.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  // Control byte layout (bit 7 reads as zero)
  typedef struct packed {
    logic spare;
    logic irq_en;
    logic fast;
    logic wide;
    logic idle_high;
    logic nine;
    logic cont;
    logic single;
  } srx_ctl_t;

  typedef enum logic [1:0] {
    SRX_A_CTL  = 2'd0,
    SRX_A_DLO  = 2'd1,
    SRX_A_DHI  = 2'd2,
    SRX_A_NONE = 2'd3
  } srx_addr_e;

endpackage

// File: rtl/sync_rx_regs.sv
module sync_rx_regs
  import sync_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             single_clr,
  output srx_ctl_t         ctl,
  output logic [DIV_W-1:0] div_q,
  output logic             cont_fall
);
  localparam int HI_W = DIV_W - 8;

  logic ctl_wr;
  assign ctl_wr    = wr_en && (wr_addr == SRX_A_CTL);
  // a write that drops a set continuous bit
  assign cont_fall = ctl_wr && ctl.cont && !wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      div_q <= '0;
    end else begin
      if (ctl_wr)
        ctl <= srx_ctl_t'(wr_data & 8'h7F);
      else if (single_clr)
        ctl.single <= 1'b0;
      if (wr_en && wr_addr == SRX_A_DLO)
        div_q[7:0] <= wr_data;
      if (wr_en && wr_addr == SRX_A_DHI)
        div_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
    end
  end

  // R5
  single_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_clr && !ctl_wr) |=> !ctl.single);

endmodule

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int DIV_W    = 16,
  parameter int SLOW_MUL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             wide,
  input  logic             fast,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1 + $clog2(SLOW_MUL);

  function automatic logic [CNT_W-1:0] half_len(input logic [DIV_W-1:0] d,
                                                 input logic w, input logic f);
    logic [CNT_W-1:0] base;
    base = w ? CNT_W'(d) : CNT_W'(d[7:0]);
    base = base + 1'b1;
    return f ? base : base * CNT_W'(SLOW_MUL);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hp;

  assign hp   = half_len(div, wide, fast);
  assign tick = run && (cnt == hp - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3
  half_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single,
  input  logic              cont,
  input  logic              nine,
  input  logic              tick,
  input  logic              sdi,
  output logic              active,
  output logic              sck_int,
  output logic              word_done,
  output logic              single_clr,
  output logic [WORD_W-1:0] word,
  output logic              bit9
);
  localparam int SH_W = WORD_W + 1;
  localparam int BC_W = $clog2(SH_W);

  logic [SH_W-1:0] sh;
  logic [BC_W-1:0] bitcnt;
  logic [BC_W-1:0] last;
  logic            phase;   // 0 = active half, 1 = idle half
  logic            enable;
  logic            sample;

  assign enable     = single || cont;
  assign last       = nine ? BC_W'(SH_W - 1) : BC_W'(SH_W - 2);
  assign sample     = active && enable && tick && !phase;
  assign word_done  = active && enable && tick && phase && (bitcnt == last);
  assign single_clr = word_done && !cont;
  assign sck_int    = active && !phase;
  assign word       = nine ? sh[WORD_W-1:0] : sh[SH_W-1:1];
  assign bit9       = nine && sh[SH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      bitcnt <= '0;
      sh     <= '0;
    end else if (!active) begin
      if (enable) begin
        active <= 1'b1;
        phase  <= 1'b0;
        bitcnt <= '0;
      end
    end else if (!enable) begin
      active <= 1'b0;
      phase  <= 1'b0;
      bitcnt <= '0;
    end else if (tick) begin
      if (!phase) begin
        sh    <= {sdi, sh[SH_W-1:1]};
        phase <= 1'b1;
      end else if (bitcnt == last) begin
        phase  <= 1'b0;
        bitcnt <= '0;
        if (!cont) active <= 1'b0;
      end else begin
        bitcnt <= bitcnt + 1'b1;
        phase  <= 1'b0;
      end
    end
  end

  // R5
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cont) |=> !active);
  // R6
  cont_next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cont) |=> (active && sck_int));
  // R4
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sck_int);

endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic              bit9,
  input  logic              rd_pop,
  input  logic              cont_fall,
  input  logic              irq_en,
  output logic [WORD_W-1:0] data_q,
  output logic              bit9_q,
  output logic              ready_q,
  output logic              ovr_q,
  output logic              irq
);
  logic accept;
  logic overrun_evt;

  assign accept      = word_done && !ovr_q && (!ready_q || rd_pop);
  assign overrun_evt = word_done && !accept;
  assign irq         = ready_q && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      bit9_q  <= 1'b0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (accept) begin
        data_q  <= word;
        bit9_q  <= bit9;
        ready_q <= 1'b1;
      end else if (rd_pop) begin
        ready_q <= 1'b0;
      end
      if (overrun_evt)    ovr_q <= 1'b1;
      else if (cont_fall) ovr_q <= 1'b0;
    end
  end

  // R10
  ovr_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ($stable(data_q) && ovr_q));
  // R9
  pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !word_done) |=> !ready_q);
  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cont_fall) |=> ovr_q);

endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int WORD_W   = 8,
  parameter int SLOW_MUL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_addr,
  input  logic [7:0]        ctl_wdata,
  input  logic              rx_pop,
  input  logic              sdi_pin,
  output logic [7:0]        ctl_state,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              rx_ovr,
  output logic              sck_pin
);
  srx_ctl_t          ctl;
  logic [DIV_W-1:0]  div_q;
  logic              cont_fall;
  logic              single_clr;
  logic              active;
  logic              sck_int;
  logic              tick;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              bit9;

  sync_rx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_addr(ctl_addr),
    .wr_data(ctl_wdata), .single_clr(single_clr), .ctl(ctl),
    .div_q(div_q), .cont_fall(cont_fall)
  );

  sync_rx_baud #(.DIV_W(DIV_W), .SLOW_MUL(SLOW_MUL)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(active), .div(div_q),
    .wide(ctl.wide), .fast(ctl.fast), .tick(tick)
  );

  sync_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .single(ctl.single), .cont(ctl.cont),
    .nine(ctl.nine), .tick(tick), .sdi(sdi_pin), .active(active),
    .sck_int(sck_int), .word_done(word_done), .single_clr(single_clr),
    .word(word), .bit9(bit9)
  );

  sync_rx_buffer #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .bit9(bit9), .rd_pop(rx_pop), .cont_fall(cont_fall),
    .irq_en(ctl.irq_en), .data_q(rx_data), .bit9_q(rx_bit9),
    .ready_q(rx_ready), .ovr_q(rx_ovr), .irq(rx_irq)
  );

  assign ctl_state = ctl;
  assign sck_pin   = sck_int ^ ctl.idle_high;

  // R12
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck_pin == ctl.idle_high));

endmodule

// File: tb/sync_rx_master_bench.sv
module sync_rx_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_addr = 2'd0;
  logic [7:0] ctl_wdata = 8'd0;
  logic       rx_pop = 1'b0;
  logic       sdi_pin = 1'b0;
  logic [7:0] ctl_state;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_ready, rx_irq, rx_ovr, sck_pin;

  sync_rx_master u_sync_rx_master (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .rx_pop(rx_pop), .sdi_pin(sdi_pin),
    .ctl_state(ctl_state), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .rx_ovr(rx_ovr), .sck_pin(sck_pin)
  );

  always #2 clk = ~clk;   // 250 MHz

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit bitq[$];
  bit idle_m = 0, irq_m = 0, per_en = 1, act_prev = 0;
  int hicnt = 0, h_exp = 4;
  int div_m = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int half_model(input int dv, input bit w, input bit f);
    int d = w ? dv : (dv % 256);
    return f ? d + 1 : 4 * d + 4;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    ctl_wr = 1; ctl_addr = 2'(a); ctl_wdata = 8'(d);
    @(negedge clk);
    ctl_wr = 0;
    if (a == 1) div_m = (div_m & 'hFF00) | (d & 'hFF);
    if (a == 2) div_m = (div_m & 'h00FF) | ((d & 'hFF) << 8);
    if (a == 0) begin
      idle_m = d[3]; irq_m = d[6];
      h_exp = half_model(div_m, d[4], d[5]);
    end
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic push(input int v, input int n);
    for (int i = 0; i < n; i++) bitq.push_back(v[i]);
  endtask

  task automatic wait_ready(input string tag);
    int k = 0;
    while (!rx_ready && k < 20000) begin @(negedge clk); k++; end
    if (!rx_ready) chk(0, {tag, " ready timeout"}, 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // serial slave and per-clock reference compare
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (sck_pin !== idle_m) hicnt++;
      else if (act_prev) begin
        if (bitq.size() > 0) void'(bitq.pop_front());
        if (per_en) chk(hicnt == h_exp, "R3 active half length", hicnt, h_exp);
        hicnt = 0;
      end
      act_prev = (sck_pin !== idle_m);
      chk(rx_irq == (rx_ready & irq_m), "R9 irq per clock", rx_irq, rx_ready & irq_m);
    end
    sdi_pin = (bitq.size() > 0) ? bitq[0] : 1'b0;
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(1);
    // R1
    chk(ctl_state == 0, "R1 ctl_state", ctl_state, 0);
    chk(rx_ready == 0 && rx_ovr == 0 && rx_irq == 0, "R1 flags", {rx_ready, rx_ovr, rx_irq}, 0);
    chk(sck_pin == 0, "R1 sck", sck_pin, 0);

    // single 8-bit word, slow narrow divider 2 -> H = 12
    wr(1, 2); wr(2, 0);
    push('hA5, 8);
    wr(0, 'h41);
    chk(ctl_state == 'h41, "R2 control readback", ctl_state, 'h41);
    wait_ready("R5");
    chk(rx_data == 'hA5, "R4 lsb-first data", rx_data, 'hA5);
    chk(rx_bit9 == 0, "R8 bit9 in 8-bit mode", rx_bit9, 0);
    chk(rx_irq == 1, "R9 irq on ready", rx_irq, 1);
    chk(ctl_state[0] == 0, "R5 single self-clear", ctl_state[0], 0);
    idle(60);
    chk(sck_pin == 0 && rx_ready == 1, "R5 stays idle", {sck_pin, rx_ready}, 1);
    pop();
    chk(rx_ready == 0 && rx_irq == 0, "R9 pop clears ready", {rx_ready, rx_irq}, 0);

    // polarity idle high
    wr(0, 'h08);
    chk(sck_pin == 1, "R12 idle high", sck_pin, 1);
    push('h3C, 8);
    wr(0, 'h09);
    wait_ready("R12");
    chk(rx_data == 'h3C, "R12 data with inverted clock", rx_data, 'h3C);
    idle(3);
    chk(sck_pin == 1, "R12 returns high", sck_pin, 1);
    pop();

    // nine-bit mode
    push('h15A, 9);
    wr(0, 'h05);
    wait_ready("R8");
    chk(rx_data == 'h5A, "R8 low bits", rx_data, 'h5A);
    chk(rx_bit9 == 1, "R8 ninth bit", rx_bit9, 1);
    pop();

    // wide fast divider: 0x0102 -> H = 259
    wr(2, 1);
    push('h81, 8);
    wr(0, 'h31);
    wait_ready("R3 wide");
    chk(rx_data == 'h81, "R3 wide divider word", rx_data, 'h81);
    pop();
    // narrow fast: low byte 2 -> H = 3
    push('h7E, 8);
    wr(0, 'h21);
    wait_ready("R3 narrow");
    chk(rx_data == 'h7E, "R3 narrow divider word", rx_data, 'h7E);
    pop();

    // continuous, overrun and recovery, H = 12
    wr(2, 0);
    push('h11, 8); push('h22, 8); push('h33, 8); push('h44, 8);
    wr(0, 'h02);
    wait_ready("R6 first");
    chk(rx_data == 'h11, "R6 first word", rx_data, 'h11);
    pop();
    wait_ready("R6 second");
    chk(rx_data == 'h22, "R6 second word", rx_data, 'h22);
    begin
      int k = 0;
      while (!rx_ovr && k < 5000) begin @(negedge clk); k++; end
    end
    chk(rx_ovr == 1, "R10 overrun set", rx_ovr, 1);
    chk(rx_data == 'h22, "R10 data held", rx_data, 'h22);
    pop();
    idle(450);
    chk(rx_ready == 0 && rx_data == 'h22, "R10 no load while overrun", {rx_ready, rx_data}, 'h022);
    wr(0, 'h42);
    chk(rx_ovr == 1, "R11 other write keeps overrun", rx_ovr, 1);
    per_en = 0;
    wr(0, 'h00);
    chk(rx_ovr == 0, "R11 clearing continuous clears overrun", rx_ovr, 0);
    idle(3);
    chk(sck_pin == 0, "R6 abort to idle", sck_pin, 0);
    idle(400);
    chk(rx_ready == 0, "R6 no completion after abort", rx_ready, 0);
    bitq.delete();
    per_en = 1;

    // both enables set
    push('h55, 8); push('h66, 8);
    wr(0, 'h03);
    wait_ready("R7 first");
    chk(rx_data == 'h55, "R7 first word", rx_data, 'h55);
    pop();
    chk(ctl_state[0] == 1, "R7 single kept", ctl_state[0], 1);
    wait_ready("R7 second");
    chk(rx_data == 'h66, "R7 continues", rx_data, 'h66);
    pop();
    per_en = 0;
    wr(0, 'h00);
    idle(3);
    chk(sck_pin == 0 && ctl_state == 0, "R6 stop after clear", {sck_pin, ctl_state}, 0);

    idle(5);
    summary();
  end
endmodule